// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

An eight-pin bidirectional I/O port with a small register bus. Software writes an output latch and a direction register and reads back the pin levels. Each pin's pad is driven from these registers through per-pin pad signals: output value, output enable, pull-up enable and open-drain select.

Several pins are shared with alternate functions. Five pins (0, 1, 2, 3 and 5) can be analog inputs. Pins 6 and 7 can be taken over by an external oscillator. Pins 1, 4 and 5 can be claimed by display segment drive. When a function other than the port owns a pin, the port changes how it treats that pin. Its pin-read bit is forced to zero. Its pad drive and pull-up are released where the function requires it. For the oscillator pins, the latch and direction read-back bits are also zeroed.

Control inputs for the analog-select code, the oscillator mode and the segment enables come from configuration registers elsewhere in the chip. The block decodes them into per-pin ownership.

Top module: `muxGpioPort`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs) and the latch register reads 0x00.
- R2: A write to address 0 or to address 1 stores the write data in the latch. A write to address 2 stores it in the direction register. Reads at address 1 and address 2 return the latch and the direction register, and address 3 reads 0.
- R3: On a pin that the port owns and that is not open-drain, padOut equals the latch bit and padOe is the inverse of the direction bit (direction 0 = output). For example, direction 0xBF enables only pin 6.
- R4: A read at address 0 returns the pad input levels through a two-stage synchronizer. A pad change made before clock edge k is visible on rdData after edge k+1 and not after edge k. The value read is the pad level, not the latch.
- R5: The analog-select input anaSel decodes to a set of analog pins. Values 7 to 15 select none. Value 6 selects pin 0, value 5 selects pins 0 and 1, value 4 selects pins 0 to 2, value 3 selects pins 0 to 3, and values 0 to 2 select pins 0, 1, 2, 3 and 5. Analog pins read 0 at address 0. With anaSel at its reset value 0, pin 4 reads as a digital input.
- R6: While oscExt is 1, bits 6 and 7 of the latch and direction reads are 0, their padOe is 0, and their port-read bits are 0. The stored register bits are kept, and they reappear when oscExt returns to 0.
- R7: segEn bit 0 claims pin 1, bit 1 claims pin 4 and bit 2 claims pin 5. A claimed pin has padOe 0, padOd 0 and a port-read bit of 0.
- R8: padPu for a pin is 1 only when puEn is 1, the pin's direction bit is 1, and the pin is not owned by the analog, segment or oscillator function.
- R9: With odEn set for a port-owned output pin, padOut is 0 and padOe is the inverse of the latch bit, so a 1 releases the pad and a 0 drives it low. padOd mirrors odEn on pins not claimed by segment or oscillator.
- R10: Analog pins keep their output enable under direction control: padOe equals the inverse of the direction bit for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 port, 1 latch, 2 direction |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from addr |
| anaSel | input | 4 | Analog-select code |
| oscExt | input | 1 | 1 = external oscillator owns pins 6 and 7 |
| segEn | input | 3 | Segment claims for pins 5, 4, 1 (bits 2..0) |
| puEn | input | 1 | Global weak pull-up enable |
| odEn | input | 8 | Per-pin open-drain select |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| padPu | output | 8 | Pad pull-up enables |
| padOd | output | 8 | Pad open-drain selects |

## Verification
The assertions check several properties on every cycle. A latch write lands on the next edge. An open-drain pad never drives high. A pull-up is never on for an output pin. Oscillator-owned pins never get an output enable. An alternate-owned pin never shows a 1 in a port read. Only the bench scenarios can show three other behaviours. The first is the exact analog-select decode across all sixteen codes. The second is the two-edge synchronizer latency. The third is that oscillator-hidden register bits survive and reappear when the mode returns to internal.

// File: rtl/gpioPkg.sv
package gpioPkg;
  localparam int PIN_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    RD_PORT  = 2'd0,
    RD_LATCH = 2'd1,
    RD_DIR   = 2'd2,
    RD_NONE  = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   latchWr;
    logic   dirWr;
    rdSel_t rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [3:0]        anaSel,
  input  logic              oscExt,
  input  logic [2:0]        segEn,
  output ctrlStrb_t         strb,
  output logic [PIN_W-1:0]  anaMask,
  output logic [PIN_W-1:0]  segMask,
  output logic [PIN_W-1:0]  oscMask
);
  always_comb begin
    strb.latchWr = wrEn && (addr == ADDR_W'(0) || addr == ADDR_W'(1));
    strb.dirWr   = wrEn && (addr == ADDR_W'(2));
    strb.rdSel   = rdSel_t'(addr);
  end

  always_comb begin
    case (anaSel)
      4'd0, 4'd1, 4'd2: anaMask = 8'h2F;
      4'd3:             anaMask = 8'h0F;
      4'd4:             anaMask = 8'h07;
      4'd5:             anaMask = 8'h03;
      4'd6:             anaMask = 8'h01;
      default:          anaMask = 8'h00;
    endcase
  end

  always_comb begin
    segMask    = '0;
    segMask[1] = segEn[0];
    segMask[4] = segEn[1];
    segMask[5] = segEn[2];
    oscMask    = {oscExt, oscExt, 6'b0};
  end
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] anaMask,
  input  logic [PIN_W-1:0] segMask,
  input  logic [PIN_W-1:0] oscMask,
  input  logic             puEn,
  input  logic [PIN_W-1:0] odEn,
  input  logic [PIN_W-1:0] padIn,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padOe,
  output logic [PIN_W-1:0] padPu,
  output logic [PIN_W-1:0] padOd
);
  logic [PIN_W-1:0] latchQ, dirQ;
  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncQ;
  logic [PIN_W-1:0] altMask, padMask, odAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '1;
    end else begin
      if (strb.latchWr) latchQ <= wrData;
      if (strb.dirWr)   dirQ   <= wrData;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= '0;
          else       syncQ[0] <= padIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    altMask = anaMask | segMask | oscMask;
    padMask = ~(segMask | oscMask);
    odAct   = odEn & padMask;
    padOut  = latchQ & ~odAct & padMask;
    padOe   = padMask & ~dirQ & ~(odAct & latchQ);
    padOd   = odAct;
    padPu   = {PIN_W{puEn}} & dirQ & ~altMask;
    case (strb.rdSel)
      RD_PORT:  rdData = syncQ[SYNC_STAGES-1] & ~altMask;
      RD_LATCH: rdData = latchQ & ~oscMask;
      RD_DIR:   rdData = dirQ & ~oscMask;
      default:  rdData = '0;
    endcase
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchWr |=> latchQ == $past(wrData)); // R2
  AST_PORT_ALT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_PORT) |-> ((rdData & altMask) == '0)); // R5
  AST_OSC_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    oscMask[7] |-> (padOe[7:6] == 2'b00)); // R6
  AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((padPu & ~dirQ) == '0)); // R8
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((padOd & padOe & padOut) == '0)); // R9
endmodule

// File: rtl/muxGpioPort.sv
module muxGpioPort
  import gpioPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [PIN_W-1:0]  wrData,
  output logic [PIN_W-1:0]  rdData,
  input  logic [3:0]        anaSel,
  input  logic              oscExt,
  input  logic [2:0]        segEn,
  input  logic              puEn,
  input  logic [PIN_W-1:0]  odEn,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe,
  output logic [PIN_W-1:0]  padPu,
  output logic [PIN_W-1:0]  padOd
);
  ctrlStrb_t        strb;
  logic [PIN_W-1:0] anaMask, segMask, oscMask;

  gpioCtrl i_ctrl (
    .addr(addr), .wrEn(wrEn), .anaSel(anaSel), .oscExt(oscExt),
    .segEn(segEn), .strb(strb), .anaMask(anaMask), .segMask(segMask),
    .oscMask(oscMask)
  );

  gpioDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .anaMask(anaMask), .segMask(segMask), .oscMask(oscMask),
    .puEn(puEn), .odEn(odEn), .padIn(padIn), .rdData(rdData),
    .padOut(padOut), .padOe(padOe), .padPu(padPu), .padOd(padOd)
  );
endmodule

// File: tb/test_muxGpioPort.sv
module test_muxGpioPort;
  logic clk = 0, rstN = 0;
  logic [1:0] addr = 0;
  logic wrEn = 0;
  logic [7:0] wrData = 0, odEn = 0, padIn = 0;
  logic [3:0] anaSel = 0;
  logic oscExt = 0, puEn = 0;
  logic [2:0] segEn = 0;
  logic [7:0] rdData, padOut, padOe, padPu, padOd;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  muxGpioPort i_muxGpioPort (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic setPad(input logic [7:0] v);
    @(negedge clk); padIn = v;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] anaM(input int a);
    int n;
    logic [7:0] m;
    int order [5] = '{0, 1, 2, 3, 5};
    n = (a >= 7) ? 0 : (a <= 2) ? 5 : 7 - a;
    m = 0;
    for (int k = 0; k < n; k++) m[order[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] segM(input int s);
    return (8'(s & 1) << 1) | (8'((s >> 1) & 1) << 4) | (8'((s >> 2) & 1) << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    rd(2, d); chk("R1 dir reset", d, 8'hFF);
    rd(1, d); chk("R1 latch reset", d, 8'h00);
    setPad(8'hFF);
    rd(0, d); chk("R5 reset analog, pin4 digital", d, 8'hD0);

    anaSel = 7;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'(i * 53 + 1);
      wr(1, v); rd(1, d); chk("R2 latch addr1", d, v);
    end
    wr(0, 8'h3C); rd(1, d); chk("R2 latch via addr0", d, 8'h3C);
    rd(3, d); chk("R2 addr3 zero", d, 8'h00);
    wr(2, 8'h00); rd(2, d); chk("R2 dir readback", d, 8'h00);
    chk("R3 padOut latch", padOut, 8'h3C);
    chk("R3 padOe all out", padOe, 8'hFF);
    wr(2, 8'hBF);
    chk("R3 only pin6 out", padOe, 8'h40);
    wr(2, 8'hFF);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] p;
      p = 8'(i * 37 + 5);
      setPad(p); rd(0, d); chk("R4 port read pad level", d, p);
    end
    @(negedge clk); padIn = 8'h0F;
    @(negedge clk); rd(0, d); chk("R4 one edge still old", d, 8'(15 * 37 + 5));
    @(negedge clk); rd(0, d); chk("R4 two edges new", d, 8'h0F);

    setPad(8'hFF);
    for (int a = 0; a < 16; a++) begin
      anaSel = 4'(a); #1;
      rd(0, d); chk("R5 analog decode read", d, ~anaM(a));
    end
    anaSel = 0; wr(2, 8'h00);
    chk("R10 analog pins follow dir", padOe, 8'hFF);
    wr(2, 8'h2F);
    chk("R10 analog pins inputs", padOe, 8'hD0);

    anaSel = 7; wr(1, 8'hFF); wr(2, 8'hFF);
    oscExt = 1; #1;
    rd(1, d); chk("R6 latch hidden", d, 8'h3F);
    rd(2, d); chk("R6 dir hidden", d, 8'h3F);
    rd(0, d); chk("R6 port read zero", d, 8'h3F);
    wr(2, 8'h00);
    chk("R6 no drive pins 6,7", padOe, 8'h3F);
    wr(2, 8'hC0);
    oscExt = 0; #1;
    rd(1, d); chk("R6 latch restored", d, 8'hFF);
    rd(2, d); chk("R6 dir restored", d, 8'hC0);

    for (int s = 0; s < 8; s++) begin
      segEn = 3'(s);
      wr(2, 8'h00);
      chk("R7 seg oe", padOe, ~segM(s));
      wr(2, 8'hFF);
      rd(0, d); chk("R7 seg port read", d, ~segM(s));
    end
    segEn = 0;

    puEn = 1;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] dv;
      dv = 8'(i * 29 + 3);
      anaSel = 4'(i % 16); segEn = 3'(i % 8); oscExt = i[4];
      wr(2, dv);
      chk("R8 pull-up", padPu,
          dv & ~(anaM(i % 16) | segM(i % 8) | (i[4] ? 8'hC0 : 8'h00)));
    end
    puEn = 0; #1;
    chk("R8 pull-up off", padPu, 8'h00);

    anaSel = 7; segEn = 0; oscExt = 0; odEn = 8'hFF;
    wr(1, 8'hA5); wr(2, 8'h00);
    chk("R9 od oe", padOe, 8'h5A);
    chk("R9 od out low", padOut, 8'h00);
    chk("R9 od select", padOd, 8'hFF);
    segEn = 3'b111; oscExt = 1; #1;
    chk("R9 od select owned", padOd, 8'h0D);
    segEn = 0; oscExt = 0;
    wr(2, 8'h0F);
    chk("R9 od input pins", padOe, 8'h50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule